// File: doc/BRIEF.md
# Conditional ALU with Flag Logic

This block is the combinational arithmetic/logic stage of a RISC processor datapath. Each operation takes a 4-bit opcode, two operands of `WIDTH` bits, the current condition flags, and the carry-out from the upstream operand shifter. In the same cycle it returns the result, a write-enable for the destination register and the next condition flags.

The sixteen opcodes fall into three groups: bitwise operations, arithmetic operations (add, subtract, reverse-subtract, and their carry-using forms), and test/compare operations. The test/compare operations update the flags but suppress writeback. A set-flags input decides whether the flags change at all. A destination-is-PC input stops the flags from being taken from the ALU. When set-flags is also high, that input raises a request so that surrounding logic can restore the saved status word.

Top module: `cond_alu`

## Requirements
- R1: Opcode map (op_i): 0 AND, 1 EOR, 2 SUB (op1-op2), 3 RSB (op2-op1), 4 ADD, 5 ADC (op1+op2+C), 6 SBC, 7 RSC, 8 TST, 9 TEQ, 10 CMP, 11 CMN, 12 ORR, 13 MOV, 14 BIC, 15 MVN. result_o is the operation's value modulo 2^WIDTH. TST/TEQ/CMP/CMN compute AND/EOR/SUB/ADD respectively.
- R2: SBC gives op1-op2+C-1 and RSC gives op2-op1+C-1, where C is flags_i[1]. Subtraction is an addition of the inverted subtrahend, so C=1 after a subtract means no borrow.
- R3: wr_en_o is 0 for opcodes 8 to 11 and 1 for every other opcode.
- R4: MOV returns op2 and MVN returns ~op2, so op1 has no effect on either. BIC returns op1 & ~op2.
- R5: For a bitwise opcode (0, 1, 8, 9, 12 to 15) with flags updated, C takes shift_co_i and V keeps flags_i[0].
- R6: For a bitwise opcode with flags updated, shift_keep_i=1 (the shift was a left shift by zero) keeps C at flags_i[1] and ignores shift_co_i.
- R7: For an arithmetic opcode (2 to 7, 10, 11) with flags updated, C is the carry out of the top bit and V flags signed overflow.
- R8: Whenever the flags are updated, N equals the top result bit and Z is 1 only for an all-zero result.
- R9: Flag order is flags[3]=N, flags[2]=Z, flags[1]=C, flags[0]=V. With set_flags_i=0, flags_o equals flags_i.
- R10: With dst_pc_i=1, flags_o equals flags_i. restore_o is 1 only when both dst_pc_i and set_flags_i are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| op1_i | input | WIDTH | First operand |
| op2_i | input | WIDTH | Second operand (already shifted) |
| flags_i | input | 4 | Current N,Z,C,V |
| shift_co_i | input | 1 | Carry-out of the operand shifter |
| shift_keep_i | input | 1 | Shift was left-by-zero; keep C |
| set_flags_i | input | 1 | Update flags from this operation |
| dst_pc_i | input | 1 | Destination is the program counter |
| result_o | output | WIDTH | Operation result |
| wr_en_o | output | 1 | Destination write enable |
| flags_o | output | 4 | Next N,Z,C,V |
| restore_o | output | 1 | Request saved-status restore |

## Verification
Three cases can coincide in one operation. The carry source changes with the opcode class: the adder supplies it for arithmetic opcodes, and the shifter or the keep rule supplies it for bitwise opcodes. The PC-destination override can also fall in the same cycle as a flag-setting compare or overflowing add. A sweep at `WIDTH`=4 covers every opcode, every operand pair and both carry values against all combinations of set-flags, PC-destination and shift-keep. Each outcome is judged against arithmetic computed with signed and unsigned integers in the bench. Directed 32-bit cases target overflow, borrow and the restore request.

// File: rtl/cond_alu_pkg.sv
package cond_alu_pkg;
  typedef enum logic [3:0] {
    OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
    OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
    OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
    OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
  } alu_op_e;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

  function automatic logic op_is_arith(alu_op_e op);
    return op inside {OP_SUB, OP_RSB, OP_ADD, OP_ADC, OP_SBC, OP_RSC, OP_CMP, OP_CMN};
  endfunction

  function automatic logic op_is_test(alu_op_e op);
    return op inside {OP_TST, OP_TEQ, OP_CMP, OP_CMN};
  endfunction
endpackage

// File: rtl/cond_alu_addsub.sv
module cond_alu_addsub
  import cond_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             c_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             co_o,
  output logic             ovf_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] x, y;
  logic             k;
  logic [WIDTH:0]   full;

  // subtract = add inverted subtrahend; carry=1 means no borrow
  always_comb begin
    x = a_i;
    y = b_i;
    k = 1'b0;
    unique case (op_i)
      OP_SUB, OP_CMP: begin x = a_i; y = ~b_i; k = 1'b1; end
      OP_RSB:         begin x = b_i; y = ~a_i; k = 1'b1; end
      OP_ADC:         begin x = a_i; y = b_i;  k = c_i;  end
      OP_SBC:         begin x = a_i; y = ~b_i; k = c_i;  end
      OP_RSC:         begin x = b_i; y = ~a_i; k = c_i;  end
      default:        begin x = a_i; y = b_i;  k = 1'b0; end
    endcase
  end

  assign full  = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, k};
  assign sum_o = full[MSB:0];
  assign co_o  = full[WIDTH];
  assign ovf_o = (x[MSB] == y[MSB]) && (full[MSB] != x[MSB]);

  always_comb begin
    if (op_i == OP_SUB) AST_SUB_DIFF: assert (sum_o == WIDTH'(a_i - b_i)); // R1
    if (op_i == OP_RSC) AST_RSC_DIFF: assert (sum_o == WIDTH'(b_i - a_i + WIDTH'(c_i) - WIDTH'(1))); // R2
  end
endmodule

// File: rtl/cond_alu_logic.sv
module cond_alu_logic
  import cond_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_AND, OP_TST: res_o = a_i & b_i;
      OP_EOR, OP_TEQ: res_o = a_i ^ b_i;
      OP_ORR:         res_o = a_i | b_i;
      OP_MOV:         res_o = b_i;
      OP_BIC:         res_o = a_i & ~b_i;
      OP_MVN:         res_o = ~b_i;
      default:        res_o = '0;
    endcase
  end

  always_comb begin
    if (op_i == OP_BIC) AST_BIC_DISJOINT: assert ((res_o & b_i) == '0); // R4
  end
endmodule

// File: rtl/cond_alu_flags.sv
module cond_alu_flags
  import cond_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] res_i,
  input  logic             arith_i,
  input  logic             co_i,
  input  logic             ovf_i,
  input  logic [3:0]       flags_i,
  input  logic             shift_co_i,
  input  logic             shift_keep_i,
  input  logic             set_flags_i,
  input  logic             dst_pc_i,
  output logic [3:0]       flags_o,
  output logic             restore_o
);
  logic upd;
  logic c_logic;

  assign upd       = set_flags_i && !dst_pc_i;
  assign restore_o = set_flags_i && dst_pc_i;
  assign c_logic   = shift_keep_i ? flags_i[FLAG_C] : shift_co_i;

  always_comb begin
    flags_o = flags_i;
    if (upd) begin
      flags_o[FLAG_N] = res_i[WIDTH-1];
      flags_o[FLAG_Z] = (res_i == '0);
      flags_o[FLAG_C] = arith_i ? co_i  : c_logic;
      flags_o[FLAG_V] = arith_i ? ovf_i : flags_i[FLAG_V];
    end
  end

  always_comb begin
    if (upd) AST_NZ_EXCL: assert (!(flags_o[FLAG_N] && flags_o[FLAG_Z])); // R8
    if (restore_o) AST_RESTORE_SRC: assert (flags_o == flags_i); // R10
  end
endmodule

// File: rtl/cond_alu.sv
module cond_alu
  import cond_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] op1_i,
  input  logic [WIDTH-1:0] op2_i,
  input  logic [3:0]       flags_i,
  input  logic             shift_co_i,
  input  logic             shift_keep_i,
  input  logic             set_flags_i,
  input  logic             dst_pc_i,
  output logic [WIDTH-1:0] result_o,
  output logic             wr_en_o,
  output logic [3:0]       flags_o,
  output logic             restore_o
);
  alu_op_e          op;
  logic             arith;
  logic [WIDTH-1:0] sum, lres;
  logic             co, ovf;

  assign op    = alu_op_e'(op_i);
  assign arith = op_is_arith(op);

  cond_alu_addsub #(.WIDTH(WIDTH)) i_addsub (
    .op_i (op), .a_i (op1_i), .b_i (op2_i), .c_i (flags_i[FLAG_C]),
    .sum_o(sum), .co_o (co), .ovf_o (ovf)
  );

  cond_alu_logic #(.WIDTH(WIDTH)) i_logic (
    .op_i(op), .a_i(op1_i), .b_i(op2_i), .res_o(lres)
  );

  assign result_o = arith ? sum : lres;
  assign wr_en_o  = !op_is_test(op);

  cond_alu_flags #(.WIDTH(WIDTH)) i_flags (
    .res_i       (result_o),
    .arith_i     (arith),
    .co_i        (co),
    .ovf_i       (ovf),
    .flags_i     (flags_i),
    .shift_co_i  (shift_co_i),
    .shift_keep_i(shift_keep_i),
    .set_flags_i (set_flags_i),
    .dst_pc_i    (dst_pc_i),
    .flags_o     (flags_o),
    .restore_o   (restore_o)
  );

  always_comb begin
    if (!set_flags_i) AST_QUIET_HOLD: assert (flags_o == flags_i); // R9
    if (dst_pc_i) AST_PC_HOLD: assert (flags_o == flags_i); // R10
    if (!arith) AST_LOGIC_KEEP_V: assert (flags_o[FLAG_V] == flags_i[FLAG_V]); // R5
    if (op inside {OP_MOV, OP_MVN}) AST_MOVE_SRC: assert ((result_o == op2_i) || (result_o == ~op2_i)); // R4
  end
endmodule

// File: tb/test_cond_alu.sv
module test_cond_alu;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  int errors = 0;
  int checks = 0;

  // 32-bit instance
  logic [3:0]  op;
  logic [31:0] a, b, res;
  logic [3:0]  fl, flo;
  logic        sco, skp, sf, pc, wr, rst;

  cond_alu #(.WIDTH(32)) i_cond_alu (
    .op_i(op), .op1_i(a), .op2_i(b), .flags_i(fl), .shift_co_i(sco),
    .shift_keep_i(skp), .set_flags_i(sf), .dst_pc_i(pc),
    .result_o(res), .wr_en_o(wr), .flags_o(flo), .restore_o(rst)
  );

  // 4-bit instance for sweeps
  logic [3:0] s_op, s_a, s_b, s_fl, s_res, s_flo;
  logic       s_sco, s_skp, s_sf, s_pc, s_wr, s_rst;

  cond_alu #(.WIDTH(4)) i_cond_alu_w4 (
    .op_i(s_op), .op1_i(s_a), .op2_i(s_b), .flags_i(s_fl), .shift_co_i(s_sco),
    .shift_keep_i(s_skp), .set_flags_i(s_sf), .dst_pc_i(s_pc),
    .result_o(s_res), .wr_en_o(s_wr), .flags_o(s_flo), .restore_o(s_rst)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [3:0] o, logic [31:0] x, logic [31:0] y, logic [3:0] f,
                       logic c, logic k, logic s, logic p);
    @(posedge clk);
    op = o; a = x; b = y; fl = f; sco = c; skp = k; sf = s; pc = p;
    @(negedge clk);
  endtask

  // reference model for WIDTH=4
  logic [3:0] m_res, m_fl;
  logic       m_wr, m_rst;
  task automatic model(int o, int x, int y, logic [3:0] f, logic c, logic k, logic s, logic p);
    int sx, sy, u, sr, ci;
    logic ar, isadd, cc, vv;
    sx = (x >= 8) ? x - 16 : x;
    sy = (y >= 8) ? y - 16 : y;
    ci = int'(f[1]);
    ar = 1'b1; isadd = 1'b1; u = 0; sr = 0;
    case (o)
      4, 11: begin u = x + y;          sr = sx + sy; end
      5:     begin u = x + y + ci;     sr = sx + sy + ci; end
      2, 10: begin u = x - y;          sr = sx - sy; isadd = 1'b0; end
      6:     begin u = x - y + ci - 1; sr = sx - sy + ci - 1; isadd = 1'b0; end
      3:     begin u = y - x;          sr = sy - sx; isadd = 1'b0; end
      7:     begin u = y - x + ci - 1; sr = sy - sx + ci - 1; isadd = 1'b0; end
      0, 8:  begin u = x & y; ar = 1'b0; end
      1, 9:  begin u = x ^ y; ar = 1'b0; end
      12:    begin u = x | y; ar = 1'b0; end
      13:    begin u = y; ar = 1'b0; end
      14:    begin u = x & (15 - y); ar = 1'b0; end
      default: begin u = 15 - y; ar = 1'b0; end
    endcase
    m_res = 4'(u & 15);
    cc = isadd ? (u >= 16) : (u >= 0);
    vv = (sr > 7) || (sr < -8);
    m_wr = !(o >= 8 && o <= 11);
    m_rst = s && p;
    m_fl = f;
    if (s && !p) begin
      m_fl[3] = m_res[3];
      m_fl[2] = (m_res == 4'd0);
      m_fl[1] = ar ? cc : (k ? f[1] : c);
      m_fl[0] = ar ? vv : f[0];
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    op = '0; a = '0; b = '0; fl = '0; sco = 0; skp = 0; sf = 0; pc = 0;
    s_op = '0; s_a = '0; s_b = '0; s_fl = '0; s_sco = 0; s_skp = 0; s_sf = 0; s_pc = 0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // idle state: AND of zeros, no flag update
    chk("R1 idle result", res, 32'h0);
    chk("R3 idle wr_en", {31'b0, wr}, 32'h1);
    chk("R9 idle flags", {28'b0, flo}, 32'h0);
    chk("R10 idle restore", {31'b0, rst}, 32'h0);

    drive(4'h2, 32'd5, 32'd3, 4'b0000, 0, 0, 1, 0);
    chk("R1 SUB result", res, 32'd2);
    chk("R7 SUB flags", {28'b0, flo}, 32'b0010);

    drive(4'h2, 32'd3, 32'd5, 4'b0000, 0, 0, 1, 0);
    chk("R7 SUB borrow result", res, 32'hFFFF_FFFE);
    chk("R8 SUB borrow flags", {28'b0, flo}, 32'b1000);

    drive(4'h4, 32'h7FFF_FFFF, 32'd1, 4'b0000, 0, 0, 1, 0);
    chk("R7 ADD ovf result", res, 32'h8000_0000);
    chk("R7 ADD ovf flags", {28'b0, flo}, 32'b1001);

    drive(4'hA, 32'd9, 32'd9, 4'b1001, 0, 0, 1, 0);
    chk("R3 CMP no write", {31'b0, wr}, 32'h0);
    chk("R8 CMP equal flags", {28'b0, flo}, 32'b0110);

    drive(4'h6, 32'd10, 32'd3, 4'b0000, 0, 0, 1, 0);
    chk("R2 SBC C=0 result", res, 32'd6);
    chk("R2 SBC flags", {28'b0, flo}, 32'b0010);

    drive(4'h7, 32'd3, 32'd10, 4'b0010, 0, 0, 1, 0);
    chk("R2 RSC C=1 result", res, 32'd7);

    drive(4'hF, 32'hFFFF, 32'h0, 4'b0001, 1, 0, 1, 0);
    chk("R4 MVN result", res, 32'hFFFF_FFFF);
    chk("R5 MVN flags", {28'b0, flo}, 32'b1011);

    drive(4'hD, 32'h1234, 32'h0, 4'b0010, 0, 1, 1, 0);
    chk("R4 MOV ignores op1", res, 32'h0);
    chk("R6 MOV keep C", {28'b0, flo}, 32'b0110);

    drive(4'hE, 32'hFF, 32'h0F, 4'b0000, 0, 0, 0, 0);
    chk("R4 BIC result", res, 32'hF0);

    drive(4'h4, 32'h7FFF_FFFF, 32'd1, 4'b0101, 0, 0, 1, 1);
    chk("R10 PC flags held", {28'b0, flo}, 32'b0101);
    chk("R10 PC restore", {31'b0, rst}, 32'h1);

    drive(4'h4, 32'h7FFF_FFFF, 32'd1, 4'b1010, 0, 0, 0, 1);
    chk("R10 PC no restore", {31'b0, rst}, 32'h0);
    chk("R9 S clear flags", {28'b0, flo}, 32'b1010);

    // sweep at WIDTH=4
    for (int o = 0; o < 16; o++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++)
          for (int c = 0; c < 2; c++)
            for (int ctl = 0; ctl < 8; ctl++) begin
              logic [3:0] ov, xv, yv, f;
              logic ss, pp, kk, sc;
              ov = 4'(o); xv = 4'(x); yv = 4'(y);
              ss = ctl[0]; pp = ctl[1]; kk = ctl[2];
              sc = xv[0] ^ yv[1];
              f = {ov[0], ov[1], c[0], xv[3] ^ yv[0]};
              @(posedge clk);
              s_op = ov; s_a = xv; s_b = yv; s_fl = f;
              s_sco = sc; s_skp = kk; s_sf = ss; s_pc = pp;
              @(negedge clk);
              model(o, x, y, f, sc, kk, ss, pp);
              chk($sformatf("R1 sweep res op=%0d a=%0d b=%0d", o, x, y), {28'b0, s_res}, {28'b0, m_res});
              chk($sformatf("R3 sweep wr op=%0d", o), {31'b0, s_wr}, {31'b0, m_wr});
              chk($sformatf("R7 sweep flags op=%0d a=%0d b=%0d ctl=%0d", o, x, y, ctl),
                  {28'b0, s_flo}, {28'b0, m_fl});
              chk("R10 sweep restore", {31'b0, s_rst}, {31'b0, m_rst});
            end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule